// File: doc/BRIEF.md
# MMU Address Translation and Fault Classifier

This unit turns one memory request into a physical address or a fault. Each request carries a 32-bit virtual address, a 2-bit access type and the processor privilege bit. It also carries the result of a TLB lookup made elsewhere: a hit flag, a multiple-hit flag, a 2-bit protection field, a dirty bit, a page-size code and a physical page number. The unit applies the fixed address-region rules first. It then checks the TLB result against the privilege level and the protection field, and checks the dirty bit on writes. Finally it composes the physical address.

The result comes back one clock after the request as a registered bundle: a valid pulse, the physical address, a fault class and the exception vector code for that class. A combinational flag tells the external TLB search whether address-space identifiers take part in matching. TLB storage, associative search and identifier comparison sit outside this unit.

Top module: `mmu_xlate`

## Requirements
- R1: Access type codes are 0 for data read, 1 for data write and 2 for instruction fetch; code 3 is handled as a data read. A request sampled with `req_valid_i` high produces `rsp_valid_o` high for exactly the next cycle, with results on the outputs at that time. With no request, `paddr_o`, `fault_o` and `excp_o` hold their values.
- R2: With `md_i`=0 (user mode), an address with bit 31 set that lies outside 0xE0000000..0xE4000000 (both ends inclusive) is an address error. It reports fault class 9 for a read, 10 for a write and 11 for a fetch, whatever the TLB inputs are.
- R3: With `md_i`=1, an address in 0x80000000..0xBFFFFFFF bypasses translation. It reports fault 0 and `paddr_o` equal to the address with bits 31:29 cleared, whatever the TLB inputs are.
- R4: On a single hit, the index {pr[1:0], md} decides access. Indices 0 and 2 deny every access. Indices 1, 4 and 5 allow read and fetch but deny write. Indices 3, 6 and 7 allow all. A denied read gives class 5, a denied write class 6 and a denied fetch class 7.
- R5: A TLB miss without multiple hit gives class 1 for a read, 2 for a write and 3 for a fetch.
- R6: A multiple hit gives class 4, taking priority over the miss and protection checks.
- R7: On success, `paddr_o` = ({ppn, 10'b0} AND NOT mask) OR (vaddr AND mask). The mask is 0x3FF, 0xFFF, 0xFFFF or 0xFFFFF for size codes 0, 1, 2 and 3.
- R8: A permitted write to a page with the dirty bit clear gives class 8 (initial page write). Reads and fetches never give class 8.
- R9: `use_asid_o` is 1 when `sv_i` is 0 or `md_i` is 0, and 0 otherwise.
- R10: Vector codes are 0x000 for class 0, 0x0A0 for classes 1, 3, 5 and 7, 0x060 for class 2, 0x140 for class 4, 0x0C0 for classes 6, 9 and 11, 0x080 for class 8, and 0x100 for class 10.
- R11: Priority is address error, then bypass, then multiple hit, then miss, then protection, then dirty. On any fault, `paddr_o` is 0.
- R12: After reset, `rsp_valid_o`, `paddr_o`, `fault_o` and `excp_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| vaddr_i | input | 32 | Virtual address |
| acc_i | input | 2 | Access type |
| md_i | input | 1 | Privilege bit, 1 = privileged |
| sv_i | input | 1 | Single virtual mode bit |
| tlb_hit_i | input | 1 | TLB lookup hit |
| tlb_multi_i | input | 1 | TLB multiple hit |
| tlb_pr_i | input | 2 | Entry protection field |
| tlb_dirty_i | input | 1 | Entry dirty bit |
| tlb_size_i | input | 2 | Entry page size code |
| tlb_ppn_i | input | 22 | Entry physical page number |
| use_asid_o | output | 1 | Identifier matching required |
| rsp_valid_o | output | 1 | Result strobe |
| paddr_o | output | 32 | Physical address |
| fault_o | output | 4 | Fault class |
| excp_o | output | 12 | Exception vector code |

## Verification
The protection check is swept over all 32 combinations of protection field, privilege bit and access type on a dirty 4 KB page. This sweep separates the read-only indices from the full-access and no-access ones, and tells the three violation classes apart. Address-region tests probe each edge of the user window and the bypass range in both privilege modes, with TLB inputs set to values that would fault, which shows which rule takes precedence. Each page size is paired with a page number and offset whose bits overlap, so a wrong mask shows up in the address. Miss, multiple-hit and clean-page writes are run across all access types so that each class and vector code is seen.

// File: rtl/mmu_xlate_pkg.sv
package mmu_xlate_pkg;
  localparam int VA_W = 32;

  typedef enum logic [1:0] {ACC_RD = 2'd0, ACC_WR = 2'd1, ACC_IF = 2'd2, ACC_RSV = 2'd3} acc_e;

  typedef enum logic [3:0] {
    FLT_NONE    = 4'd0,
    FLT_RD_MISS = 4'd1,
    FLT_WR_MISS = 4'd2,
    FLT_IF_MISS = 4'd3,
    FLT_MULTI   = 4'd4,
    FLT_RD_VIOL = 4'd5,
    FLT_WR_VIOL = 4'd6,
    FLT_IF_VIOL = 4'd7,
    FLT_INIT_WR = 4'd8,
    FLT_ADR_RD  = 4'd9,
    FLT_ADR_WR  = 4'd10,
    FLT_ADR_IF  = 4'd11
  } fault_e;

  localparam logic [VA_W-1:0] USR_WIN_LO = 32'hE000_0000;
  localparam logic [VA_W-1:0] USR_WIN_HI = 32'hE400_0000;
  localparam logic [VA_W-1:0] BYP_MASK   = 32'h1FFF_FFFF;

  // page offset width per size code
  localparam int SIZE_SHIFT [4] = '{10, 12, 16, 20};

  function automatic logic [11:0] fault_code(fault_e f);
    case (f)
      FLT_NONE:                                        return 12'h000;
      FLT_RD_MISS, FLT_IF_MISS, FLT_RD_VIOL, FLT_IF_VIOL: return 12'h0A0;
      FLT_WR_MISS:                                     return 12'h060;
      FLT_MULTI:                                       return 12'h140;
      FLT_INIT_WR:                                     return 12'h080;
      FLT_WR_VIOL, FLT_ADR_RD, FLT_ADR_IF:             return 12'h0C0;
      FLT_ADR_WR:                                      return 12'h100;
      default:                                         return 12'h000;
    endcase
  endfunction
endpackage

// File: rtl/mmu_region_chk.sv
module mmu_region_chk
  import mmu_xlate_pkg::*;
(
  input  logic [VA_W-1:0] vaddr_i,
  input  logic            md_i,
  output logic            addr_err_o,
  output logic            bypass_o
);
  logic in_win;
  assign in_win     = (vaddr_i >= USR_WIN_LO) && (vaddr_i <= USR_WIN_HI);
  assign addr_err_o = !md_i && vaddr_i[VA_W-1] && !in_win;
  assign bypass_o   = (vaddr_i[VA_W-1:VA_W-2] == 2'b10);
endmodule

// File: rtl/mmu_prot_chk.sv
module mmu_prot_chk (
  input  logic [1:0] pr_i,
  input  logic       md_i,
  input  logic       is_wr_i,
  output logic       viol_o
);
  logic [2:0] idx;
  logic       rd_ok, wr_ok;

  assign idx = {pr_i, md_i};

  always_comb begin
    rd_ok = 1'b0;
    wr_ok = 1'b0;
    case (idx)
      3'd1, 3'd4, 3'd5: rd_ok = 1'b1;
      3'd3, 3'd6, 3'd7: begin rd_ok = 1'b1; wr_ok = 1'b1; end
      default: ;
    endcase
  end

  assign viol_o = is_wr_i ? !wr_ok : !rd_ok;
endmodule

// File: rtl/mmu_addr_comp.sv
module mmu_addr_comp
  import mmu_xlate_pkg::*;
#(
  parameter int PPN_W    = 22,
  parameter int PG_SHIFT = 10,
  localparam int PA_W    = PPN_W + PG_SHIFT
) (
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [1:0]       size_i,
  input  logic [PPN_W-1:0] ppn_i,
  output logic [PA_W-1:0]  paddr_o
);
  logic [PA_W-1:0] mask_tbl [4];
  logic [PA_W-1:0] mask, base, voff;

  for (genvar g = 0; g < 4; g++) begin : g_mask
    assign mask_tbl[g] = PA_W'((64'd1 << SIZE_SHIFT[g]) - 64'd1);
  end

  assign mask    = mask_tbl[size_i];
  assign base    = {ppn_i, {PG_SHIFT{1'b0}}};
  assign voff    = PA_W'(vaddr_i);
  assign paddr_o = (base & ~mask) | (voff & mask);
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
  import mmu_xlate_pkg::*;
#(
  parameter int PPN_W    = 22,
  parameter int PG_SHIFT = 10,
  localparam int PA_W    = PPN_W + PG_SHIFT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [31:0]      vaddr_i,
  input  logic [1:0]       acc_i,
  input  logic             md_i,
  input  logic             sv_i,
  input  logic             tlb_hit_i,
  input  logic             tlb_multi_i,
  input  logic [1:0]       tlb_pr_i,
  input  logic             tlb_dirty_i,
  input  logic [1:0]       tlb_size_i,
  input  logic [PPN_W-1:0] tlb_ppn_i,
  output logic             use_asid_o,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic [3:0]       fault_o,
  output logic [11:0]      excp_o
);
  logic            is_wr, is_if;
  logic            addr_err, bypass, viol;
  logic [PA_W-1:0] tlb_pa;
  fault_e          flt_d;
  logic [PA_W-1:0] pa_d;

  assign is_wr = (acc_e'(acc_i) == ACC_WR);
  assign is_if = (acc_e'(acc_i) == ACC_IF);

  assign use_asid_o = !sv_i || !md_i;

  mmu_region_chk u_region (
    .vaddr_i   (vaddr_i),
    .md_i      (md_i),
    .addr_err_o(addr_err),
    .bypass_o  (bypass)
  );

  mmu_prot_chk u_prot (
    .pr_i   (tlb_pr_i),
    .md_i   (md_i),
    .is_wr_i(is_wr),
    .viol_o (viol)
  );

  mmu_addr_comp #(.PPN_W(PPN_W), .PG_SHIFT(PG_SHIFT)) u_comp (
    .vaddr_i(vaddr_i),
    .size_i (tlb_size_i),
    .ppn_i  (tlb_ppn_i),
    .paddr_o(tlb_pa)
  );

  // priority: address error > bypass > multi > miss > protection > dirty
  always_comb begin
    flt_d = FLT_NONE;
    pa_d  = '0;
    if (addr_err) begin
      flt_d = is_wr ? FLT_ADR_WR : (is_if ? FLT_ADR_IF : FLT_ADR_RD);
    end else if (bypass) begin
      pa_d = PA_W'(vaddr_i & BYP_MASK);
    end else if (tlb_multi_i) begin
      flt_d = FLT_MULTI;
    end else if (!tlb_hit_i) begin
      flt_d = is_wr ? FLT_WR_MISS : (is_if ? FLT_IF_MISS : FLT_RD_MISS);
    end else if (viol) begin
      flt_d = is_wr ? FLT_WR_VIOL : (is_if ? FLT_IF_VIOL : FLT_RD_VIOL);
    end else if (is_wr && !tlb_dirty_i) begin
      flt_d = FLT_INIT_WR;
    end else begin
      pa_d = tlb_pa;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      paddr_o     <= '0;
      fault_o     <= '0;
      excp_o      <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        paddr_o <= pa_d;
        fault_o <= flt_d;
        excp_o  <= fault_code(flt_d);
      end
    end
  end
endmodule

// File: rtl/mmu_xlate_chk.sv
module mmu_xlate_chk #(
  parameter int PA_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic [31:0]     vaddr_i,
  input logic [1:0]      acc_i,
  input logic            md_i,
  input logic            rsp_valid_o,
  input logic [PA_W-1:0] paddr_o,
  input logic [3:0]      fault_o,
  input logic [11:0]     excp_o
);
  // R1
  rsp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  // R1
  rsp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  // R1
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(paddr_o) && $stable(fault_o) && $stable(excp_o)));
  // R2
  user_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !md_i && vaddr_i[31:29] == 3'b100) |=> (fault_o >= 4'd9 && fault_o <= 4'd11));
  // R3
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && md_i && vaddr_i[31:30] == 2'b10) |=>
      (fault_o == 4'd0 && paddr_o == PA_W'($past(vaddr_i) & 32'h1FFF_FFFF)));
  // R8
  init_wr_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && acc_i != 2'd1) |=> (fault_o != 4'd8));
  // R10
  ok_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && fault_o == 4'd0) |-> (excp_o == 12'h000));
  // R11
  fault_pa_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && fault_o != 4'd0) |-> (paddr_o == '0));
endmodule

bind mmu_xlate mmu_xlate_chk #(.PA_W(PA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .vaddr_i    (vaddr_i),
  .acc_i      (acc_i),
  .md_i       (md_i),
  .rsp_valid_o(rsp_valid_o),
  .paddr_o    (paddr_o),
  .fault_o    (fault_o),
  .excp_o     (excp_o)
);

// File: tb/mmu_xlate_tb_top.sv
module mmu_xlate_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] vaddr_i = '0;
  logic [1:0]  acc_i = '0;
  logic        md_i = 1'b0;
  logic        sv_i = 1'b0;
  logic        tlb_hit_i = 1'b0;
  logic        tlb_multi_i = 1'b0;
  logic [1:0]  tlb_pr_i = '0;
  logic        tlb_dirty_i = 1'b0;
  logic [1:0]  tlb_size_i = '0;
  logic [21:0] tlb_ppn_i = '0;
  logic        use_asid_o, rsp_valid_o;
  logic [31:0] paddr_o;
  logic [3:0]  fault_o;
  logic [11:0] excp_o;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mmu_xlate dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] ref_code(input logic [3:0] f);
    case (f)
      4'd0: return 12'h000;
      4'd1, 4'd3, 4'd5, 4'd7: return 12'h0A0;
      4'd2: return 12'h060;
      4'd4: return 12'h140;
      4'd8: return 12'h080;
      4'd6, 4'd9, 4'd11: return 12'h0C0;
      4'd10: return 12'h100;
      default: return 12'hFFF;
    endcase
  endfunction

  function automatic void ref_calc(output logic [3:0] f, output logic [31:0] pa);
    logic wr, fe, rd_ok, wr_ok;
    logic [2:0] idx;
    logic [31:0] m;
    wr = (acc_i == 2'd1);
    fe = (acc_i == 2'd2);
    idx = {tlb_pr_i, md_i};
    rd_ok = (idx == 3'd1) || (idx >= 3'd3);
    wr_ok = (idx == 3'd3) || (idx >= 3'd6);
    case (tlb_size_i)
      2'd0: m = 32'h3FF;
      2'd1: m = 32'hFFF;
      2'd2: m = 32'hFFFF;
      default: m = 32'hFFFFF;
    endcase
    f = 4'd0;
    pa = '0;
    if (!md_i && vaddr_i[31] && (vaddr_i < 32'hE000_0000 || vaddr_i > 32'hE400_0000))
      f = wr ? 4'd10 : (fe ? 4'd11 : 4'd9);
    else if (vaddr_i >= 32'h8000_0000 && vaddr_i <= 32'hBFFF_FFFF)
      pa = {3'b000, vaddr_i[28:0]};
    else if (tlb_multi_i) f = 4'd4;
    else if (!tlb_hit_i) f = wr ? 4'd2 : (fe ? 4'd3 : 4'd1);
    else if (wr ? !wr_ok : !rd_ok) f = wr ? 4'd6 : (fe ? 4'd7 : 4'd5);
    else if (wr && !tlb_dirty_i) f = 4'd8;
    else pa = ({tlb_ppn_i, 10'b0} & ~m) | (vaddr_i & m);
  endfunction

  // drive one request, sample result after the capturing edge
  task automatic issue(input string req);
    logic [3:0] ef;
    logic [31:0] epa;
    ref_calc(ef, epa);
    @(negedge clk_i);
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(rsp_valid_o == 1'b1, "R1", {31'b0, rsp_valid_o}, 32'd1);
    chk(fault_o == ef, req, {28'b0, fault_o}, {28'b0, ef});
    chk(excp_o == ref_code(ef), "R10", {20'b0, excp_o}, {20'b0, ref_code(ef)});
    chk(paddr_o == epa, req, paddr_o, epa);
  endtask

  task automatic set_req(input logic [31:0] va, input logic [1:0] acc, input logic md,
                         input logic hit, input logic multi, input logic [1:0] pr,
                         input logic dirty, input logic [1:0] sz, input logic [21:0] ppn);
    @(negedge clk_i);
    vaddr_i = va; acc_i = acc; md_i = md; tlb_hit_i = hit; tlb_multi_i = multi;
    tlb_pr_i = pr; tlb_dirty_i = dirty; tlb_size_i = sz; tlb_ppn_i = ppn;
  endtask

  task automatic t_reset();
    chk(rsp_valid_o == 0, "R12", {31'b0, rsp_valid_o}, 0);
    chk(paddr_o == 0, "R12", paddr_o, 0);
    chk(fault_o == 0, "R12", {28'b0, fault_o}, 0);
    chk(excp_o == 0, "R12", {20'b0, excp_o}, 0);
  endtask

  task automatic t_prot_sweep();
    for (int p = 0; p < 4; p++)
      for (int m = 0; m < 2; m++)
        for (int a = 0; a < 4; a++) begin
          set_req(32'h0012_3456, 2'(a), 1'(m), 1, 0, 2'(p), 1, 2'd1, 22'h00ABC);
          issue("R4");
        end
  endtask

  task automatic t_miss_multi();
    for (int a = 0; a < 3; a++) begin
      set_req(32'h0040_0000, 2'(a), 1, 0, 0, 2'd3, 1, 2'd0, 22'h1);
      issue("R5");
      set_req(32'h0040_0000, 2'(a), 1, 1, 1, 2'd0, 0, 2'd0, 22'h1);
      issue("R6");
      set_req(32'h0040_0000, 2'(a), 0, 0, 1, 2'd0, 0, 2'd0, 22'h1);
      issue("R6");
    end
  endtask

  task automatic t_region();
    logic [31:0] va [8] = '{32'h8000_0000, 32'hBFFF_FFFF, 32'hC000_0000, 32'hDFFF_FFFF,
                            32'hE000_0000, 32'hE400_0000, 32'hE400_0001, 32'h7FFF_FFFF};
    for (int i = 0; i < 8; i++)
      for (int m = 0; m < 2; m++)
        for (int a = 0; a < 3; a++) begin
          set_req(va[i], 2'(a), 1'(m), 0, 1, 2'd0, 0, 2'd3, 22'h3FFFFF);
          issue(m ? "R3" : "R2");
          set_req(va[i], 2'(a), 1'(m), 1, 0, 2'd3, 1, 2'd2, 22'h12345);
          issue("R11");
        end
  endtask

  task automatic t_sizes();
    for (int s = 0; s < 4; s++) begin
      set_req(32'h5A5A_5A5A, 2'd0, 1, 1, 0, 2'd1, 0, 2'(s), 22'h3F0F0F);
      issue("R7");
      set_req(32'h0F0F_FFFF, 2'd1, 0, 1, 0, 2'd3, 1, 2'(s), 22'h2AAAAA);
      issue("R7");
    end
  endtask

  task automatic t_dirty();
    for (int a = 0; a < 3; a++) begin
      set_req(32'h1000_0800, 2'(a), 1, 1, 0, 2'd3, 0, 2'd1, 22'h777);
      issue("R8");
    end
    set_req(32'h1000_0800, 2'd1, 1, 1, 0, 2'd1, 0, 2'd1, 22'h777);
    issue("R8");
  endtask

  task automatic t_hold();
    logic [31:0] pa0;
    logic [3:0] f0;
    set_req(32'h0000_1234, 2'd0, 1, 1, 0, 2'd3, 1, 2'd1, 22'h55);
    issue("R1");
    pa0 = paddr_o; f0 = fault_o;
    set_req(32'hFFFF_0000, 2'd1, 0, 0, 1, 2'd0, 0, 2'd0, 22'h0);
    repeat (2) @(negedge clk_i);
    chk(rsp_valid_o == 0, "R1", {31'b0, rsp_valid_o}, 0);
    chk(paddr_o == pa0, "R1", paddr_o, pa0);
    chk(fault_o == f0, "R1", {28'b0, fault_o}, {28'b0, f0});
  endtask

  task automatic t_asid();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      sv_i = i[0]; md_i = i[1];
      #1;
      chk(use_asid_o == (!sv_i || !md_i), "R9", {31'b0, use_asid_o}, {31'b0, (!sv_i || !md_i)});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_prot_sweep();
    t_miss_multi();
    t_region();
    t_sizes();
    t_dirty();
    t_hold();
    t_asid();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule